// File: doc/BRIEF.md
# Video Interrupt Level Controller

This block collects three interrupt causes for an auto-vectored processor: a once-per-frame vertical-blank pulse, a 32-bit programmable down-count timer stepped by a pixel-clock enable, and a boot condition that is raised by system reset. Each cause is held in its own pending flag. The highest pending level appears on a 3-bit active-low priority code.

Software uses a small write-only bus. It loads the timer's reload value in two 16-bit halves and clears pending flags through an acknowledge register, in which each bit set to one clears one flag. A flag that has not been acknowledged stays set, so a repeated event has no visible effect until software clears it. The `alt_map` input swaps the levels of the vertical-blank and timer causes.

The timer is a two-state machine. `T_IDLE` is entered at reset; in this state the counter does not move and never fires. The transition `T_IDLE -> T_RUN` happens on the first write of the reload low half. `T_RUN` then holds until reset. In `T_RUN`, on each pixel enable, a counter at zero fires and reloads, and any other value decrements by one.

Top module: `vidirq_ctrl`

## Requirements
- R1: After reset only the boot flag is pending, so `ipl_n` reads 3'b100 (level 3).
- R2: A write to address 2 clears each flag whose data bit is one: bit 2 clears vertical blank, bit 1 clears timer, bit 0 clears boot. A cleared flag no longer contributes to `ipl_n`.
- R3: A one-cycle `vblank_start` pulse sets the vertical-blank flag. In default mapping (`alt_map`=0) this is level 1, so `ipl_n` reads 3'b110.
- R4: A set flag stays set through repeated events and through acknowledge writes whose bit for that flag is zero.
- R5: A write to address 0 stores reload bits 31:16. A write to address 1 stores reload bits 15:0 and loads the counter with the full reload value. In `T_RUN`, each `pix_en` cycle either fires (counter at zero) and reloads, or decrements. A reload value N therefore fires on every (N+1)th enable.
- R6: In default mapping the timer is level 2 and wins over vertical blank; boot (level 3) wins over both.
- R7: With `alt_map`=1 the timer is level 1 and vertical blank is level 2.
- R8: Writing 3'b111 to the acknowledge register clears all three flags in one cycle, and `ipl_n` reads 3'b111 when nothing is pending.
- R9: With reload 0 and `pix_en` held high, the timer fires on every cycle. An acknowledge of the timer flag in any of those cycles leaves the flag set.
- R10: When an event and the acknowledge of its own flag arrive in the same cycle, the flag ends set.
- R11: Before the first low-half write the timer stays in `T_IDLE` and never fires, whatever `pix_en` does.
- R12: A write to address 3 changes no flag and no timer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; steps the timer |
| vblank_start | input | 1 | One-cycle pulse when a new frame starts |
| alt_map | input | 1 | 1 swaps the vertical-blank and timer levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 reload high, 1 reload low, 2 acknowledge, 3 unused |
| wr_data | input | 16 | Write data |
| ipl_n | output | 3 | Active-low highest pending level |

## Verification
The assertions assume that `vblank_start` and `wr_en` are synchronous to `clk` and that at most one register write happens per cycle. The bench drives every input a fixed delay after the rising edge and issues writes one at a time. The bench also keeps the reload value small, so that the timer periods it checks are reached in a few dozen enables.

// File: rtl/vidirq_pkg.sv
`timescale 1ns/1ps
package vidirq_pkg;
    localparam int unsigned LVL_W = 3;

    typedef enum logic [1:0] {
        A_RELOAD_HI = 2'd0,
        A_RELOAD_LO = 2'd1,
        A_ACK       = 2'd2,
        A_SPARE     = 2'd3
    } reg_addr_e;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_RUN  = 1'b1
    } tmr_state_e;

    // bit order matches the acknowledge register: [2] vblank, [1] timer, [0] boot
    typedef struct packed {
        logic vblank;
        logic timer;
        logic boot;
    } src_t;
endpackage

// File: rtl/vidirq_timer.sv
`timescale 1ns/1ps
module vidirq_timer
    import vidirq_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [CNT_W/2-1:0] wr_half,
    output logic               fire
);
    localparam int unsigned HALF_W = CNT_W / 2;

    tmr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  rel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:  if (wr_lo) state_d = T_RUN;
            T_RUN:   state_d = T_RUN;
            default: state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_hi) rel_q[CNT_W-1:HALF_W] <= wr_half;
            if (wr_lo) begin
                rel_q[HALF_W-1:0] <= wr_half;
                cnt_q             <= {rel_q[CNT_W-1:HALF_W], wr_half};
            end else if (state_q == T_RUN && pix_en) begin
                if (cnt_q == '0) cnt_q <= rel_q;
                else             cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            T_IDLE:  fire = 1'b0;
            T_RUN:   fire = pix_en && !wr_lo && (cnt_q == '0);
            default: fire = 1'b0;
        endcase
    end

    // R5: after a fire the counter holds the reload value
    p_reload_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cnt_q == $past(rel_q));
    // R11: no fire while idle
    p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_IDLE) |-> !fire);
    // R5: a low-half write loads the counter
    p_lo_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_q[HALF_W-1:0] == $past(wr_half));
endmodule

// File: rtl/vidirq_pending.sv
`timescale 1ns/1ps
module vidirq_pending
    import vidirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_t set_i,
    input  src_t clr_i,
    output src_t flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '{vblank: 1'b0, timer: 1'b0, boot: 1'b1};
        else        flags_o <= set_i | (flags_o & ~clr_i);
    end

    // R4: a flag not acknowledged stays set
    p_vb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o.vblank && !clr_i.vblank) |=> flags_o.vblank);
    // R10: an event beats a simultaneous acknowledge
    p_tm_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.timer |=> flags_o.timer);
    // R2: acknowledge clears boot
    p_boot_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i.boot && !set_i.boot) |=> !flags_o.boot);
endmodule

// File: rtl/vidirq_encode.sv
`timescale 1ns/1ps
module vidirq_encode
    import vidirq_pkg::*;
(
    input  src_t             flags_i,
    input  logic             alt_map,
    output logic [LVL_W-1:0] ipl_n
);
    logic             lvl2_src;
    logic [LVL_W-1:0] lvl;

    always_comb begin
        lvl2_src = alt_map ? flags_i.vblank : flags_i.timer;
        if (flags_i.boot)                         lvl = 3'd3;
        else if (lvl2_src)                        lvl = 3'd2;
        else if (flags_i.vblank || flags_i.timer) lvl = 3'd1;
        else                                      lvl = 3'd0;
        ipl_n = ~lvl;
    end
endmodule

// File: rtl/vidirq_ctrl.sv
`timescale 1ns/1ps
module vidirq_ctrl
    import vidirq_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic               vblank_start,
    input  logic               alt_map,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic [2:0]         ipl_n
);
    reg_addr_e addr;
    logic      wr_hi, wr_lo, wr_ack, tmr_fire;
    src_t      set_s, clr_s, flags;

    always_comb begin
        addr   = reg_addr_e'(wr_addr);
        wr_hi  = wr_en && (addr == A_RELOAD_HI);
        wr_lo  = wr_en && (addr == A_RELOAD_LO);
        wr_ack = wr_en && (addr == A_ACK);
        set_s  = '{vblank: vblank_start, timer: tmr_fire, boot: 1'b0};
        clr_s  = wr_ack ? src_t'(wr_data[2:0]) : src_t'(3'b000);
    end

    vidirq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_half(wr_data), .fire(tmr_fire)
    );

    vidirq_pending pend_i (
        .clk(clk), .rst_n(rst_n), .set_i(set_s), .clr_i(clr_s), .flags_o(flags)
    );

    vidirq_encode enc_i (
        .flags_i(flags), .alt_map(alt_map), .ipl_n(ipl_n)
    );

    // R1/R6: boot pending always shows level 3
    p_boot_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flags.boot |-> ipl_n == 3'b100);
    // R8: nothing pending reads all ones
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000) |-> ipl_n == 3'b111);
    // R7: alternate mapping puts a lone timer at level 1
    p_alt_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_map && flags == 3'b010) |-> ipl_n == 3'b110);
    // R12: a spare-address write never clears a flag
    p_spare_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SPARE && flags.vblank) |=> flags.vblank);
endmodule

// File: tb/vidirq_ctrl_tb.sv
`timescale 1ns/1ps
module vidirq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0, vblank_start = 1'b0, alt_map = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [2:0]  ipl_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vidirq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .vblank_start(vblank_start),
        .alt_map(alt_map), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ipl_n(ipl_n)
    );

    // behavioural reference model
    bit          m_vb, m_tm, m_bt, m_run;
    longint      m_cnt, m_rel;

    initial begin
        m_vb = 0; m_tm = 0; m_bt = 1; m_run = 0; m_cnt = 0; m_rel = 0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vb = 0; m_tm = 0; m_bt = 1; m_run = 0; m_cnt = 0; m_rel = 0;
        end else begin
            bit [2:0] ack;
            bit tfire, lo;
            ack   = (wr_en && wr_addr == 2) ? wr_data[2:0] : 3'b000;
            lo    = wr_en && wr_addr == 1;
            tfire = m_run && pix_en && !lo && m_cnt == 0;
            m_vb  = vblank_start || (m_vb && !ack[2]);
            m_tm  = tfire || (m_tm && !ack[1]);
            m_bt  = m_bt && !ack[0];
            if (lo) begin
                m_rel = (m_rel / 65536) * 65536 + wr_data;
                m_cnt = m_rel;
                m_run = 1;
            end else if (m_run && pix_en) begin
                if (m_cnt == 0) m_cnt = m_rel;
                else            m_cnt = m_cnt - 1;
            end
            if (wr_en && wr_addr == 0) m_rel = longint'(wr_data) * 65536 + (m_rel % 65536);
        end
    end

    function automatic logic [2:0] model_ipl();
        int lvl;
        if (m_bt)                          lvl = 3;
        else if (alt_map ? m_vb : m_tm)    lvl = 2;
        else if (m_vb || m_tm)             lvl = 1;
        else                               lvl = 0;
        return ~3'(lvl);
    endfunction

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: ipl_n=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // R6 per-cycle comparison against the model
    always @(negedge clk) if (rst_n && !done) check(ipl_n, model_ipl(), "R6 model");

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 0; wr_data = 0;
    endtask

    task automatic vb_pulse();
        vblank_start = 1; cyc(1); vblank_start = 0;
    endtask

    task automatic pix(input int n);
        repeat (n) begin pix_en = 1; cyc(1); pix_en = 0; end
    endtask

    initial begin
        #100000000;
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog: ipl_n=%b expected=done", ipl_n);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        check(ipl_n, 3'b100, "R1 reset");
        wr(2, 16'h0001);
        check(ipl_n, 3'b111, "R2 ack boot");
        pix_en = 1; cyc(10); pix_en = 0;
        check(ipl_n, 3'b111, "R11 idle timer");
        vb_pulse();
        check(ipl_n, 3'b110, "R3 vblank level1");
        cyc(5); vb_pulse();
        check(ipl_n, 3'b110, "R4 repeat event");
        wr(2, 16'h0003);
        check(ipl_n, 3'b110, "R4 other bits ack");
        wr(3, 16'h0007);
        check(ipl_n, 3'b110, "R12 spare address");
        wr(2, 16'h0004);
        check(ipl_n, 3'b111, "R2 ack vblank");
        wr(0, 16'h0000);
        wr(1, 16'h0003);
        pix(3);
        check(ipl_n, 3'b111, "R5 before zero");
        pix(1);
        check(ipl_n, 3'b101, "R5 fire level2");
        vb_pulse();
        check(ipl_n, 3'b101, "R6 timer over vblank");
        alt_map = 1; cyc(1);
        check(ipl_n, 3'b101, "R7 alt vblank level2");
        wr(2, 16'h0004);
        check(ipl_n, 3'b110, "R7 alt timer level1");
        alt_map = 0; cyc(1);
        check(ipl_n, 3'b101, "R6 default timer level2");
        wr(2, 16'h0002);
        check(ipl_n, 3'b111, "R2 ack timer");
        pix(3);
        check(ipl_n, 3'b111, "R5 reload period");
        pix(1);
        check(ipl_n, 3'b101, "R5 second fire");
        vb_pulse();
        wr(2, 16'h0007);
        check(ipl_n, 3'b111, "R8 ack all");
        vblank_start = 1; wr_en = 1; wr_addr = 2; wr_data = 16'h0004;
        cyc(1);
        vblank_start = 0; wr_en = 0; wr_data = 0;
        check(ipl_n, 3'b110, "R10 set beats ack");
        wr(2, 16'h0004);
        wr(1, 16'h0000);
        pix_en = 1; cyc(1);
        check(ipl_n, 3'b101, "R9 flood fire");
        for (int i = 0; i < 5; i++) begin
            wr(2, 16'h0002);
            check(ipl_n, 3'b101, "R9 ack under flood");
        end
        pix_en = 0; cyc(1);
        wr(2, 16'h0002);
        check(ipl_n, 3'b111, "R9 flood stopped");
        cyc(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule